// File: doc/BRIEF.md
# Eight-Bit Bidirectional GPIO Port with Standby Control

This block is a general-purpose I/O port of `WIDTH` pins (eight by default), accessed through a small register bus. Software sets the level each pin drives through an output latch register. It chooses which pins drive and which only listen through a direction register. It observes the port through a read-only status view. Each pin drives when its direction bit is 1 and listens when it is 0. Incoming pin levels pass through a two-stage synchronizer before software can see them.

The status view mixes two sources, one per bit. An output bit returns what the latch holds. An input bit returns the synchronized pin. Two standby inputs manage power states. Hardware standby wipes the latch and the direction register while it is asserted. Software standby freezes everything: bus writes are refused and the sampled pin image stops updating, so a status read returns the last image. Hardware standby wins over software standby, and both win over bus writes.

Top module: `gpio_port_std`

## Requirements
- R1: After synchronous reset, the latch, the direction register and `rd_data` are all 0x00, so `pin_oe` and `pin_out` are 0x00.
- R2: A write to address 0 stores `wr_data` in the output latch. `pin_out` shows it on the next cycle, and a read of address 0 returns it.
- R3: A write to address 1 stores the direction register (1 = output). `pin_oe` equals it on the next cycle, and a read of address 1 returns it.
- R4: A read of address 2 (status) returns, for each bit, the latch bit where the direction bit is 1 and the synchronized pin level where it is 0.
- R5: A pin change reaches the status view only through two flops. A status read sampled on the second clock edge after the change returns the old level. One sampled on the third edge returns the new level.
- R6: A bus write to address 2 changes neither the latch nor the direction register.
- R7: `rd_data` is registered. It takes the selected value on the clock edge that samples `rd_en` and holds while `rd_en` is low. A read of address 3 returns 0x00.
- R8: While `hw_stby` is high, the latch and the direction register are cleared, even when a write arrives in the same cycle. A status read then returns the pin levels.
- R9: While `sw_stby` is high, writes are ignored and the latch and direction register keep their contents. The sampled pin image is frozen, so status reads return the value from before standby.
- R10: When `hw_stby` and `sw_stby` are both high, hardware standby wins and the registers clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_stby | input | 1 | Hardware standby: clears registers |
| sw_stby | input | 1 | Software standby: freezes registers and pin image |
| addr | input | 2 | Register select: 0 latch, 1 direction, 2 status |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wr_data | input | WIDTH | Write data |
| rd_data | output | WIDTH | Registered read data |
| pin_in | input | WIDTH | Asynchronous pin levels |
| pin_out | output | WIDTH | Level driven on each pin |
| pin_oe | output | WIDTH | Per-pin output enable |

## Verification
The status view is read under three direction patterns: all inputs, all outputs, and an alternating mix. Each pattern uses pin and latch values that differ in every bit, so a bit taken from the wrong source shows up. Pin changes are timed against read strobes to separate a two-flop synchronizer from one that is shorter or longer. The standby scenarios pair a write with each standby input, and then both inputs together, to expose a wrong priority order. A pin change made during software standby shows whether the sampled image really freezes.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_LATCH  = 2'd0,
        REG_DIR    = 2'd1,
        REG_STATUS = 2'd2,
        REG_NONE   = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        MODE_RUN,
        MODE_SW_HOLD,
        MODE_HW_CLEAR
    } pwr_mode_e;

    function automatic pwr_mode_e pick_mode(input logic hw, input logic sw);
        if (hw)      return MODE_HW_CLEAR;
        else if (sw) return MODE_SW_HOLD;
        else         return MODE_RUN;
    endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else if (!hold) begin
            stage_q[0] <= async_in;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  pwr_mode_e        mode,
    input  logic             wr_en,
    input  reg_sel_e         sel,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] latch_q,
    output logic [WIDTH-1:0] dir_q
);
    always_ff @(posedge clk) begin
        if (rst || mode == MODE_HW_CLEAR) begin
            latch_q <= '0;
            dir_q   <= '0;
        end else if (mode == MODE_RUN && wr_en) begin
            case (sel)
                REG_LATCH: latch_q <= wr_data;
                REG_DIR:   dir_q   <= wr_data;
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/gpio_rdmux.sv
module gpio_rdmux
    import gpio_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_en,
    input  reg_sel_e         sel,
    input  logic [WIDTH-1:0] latch_q,
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] pins_sync,
    output logic [WIDTH-1:0] rd_q
);
    logic [WIDTH-1:0] status_v;
    logic [WIDTH-1:0] sel_v;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        assign status_v[b] = dir_q[b] ? latch_q[b] : pins_sync[b];
    end

    always_comb begin
        case (sel)
            REG_LATCH:  sel_v = latch_q;
            REG_DIR:    sel_v = dir_q;
            REG_STATUS: sel_v = status_v;
            default:    sel_v = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        rd_q <= '0;
        else if (rd_en) rd_q <= sel_v;
    end
endmodule

// File: rtl/gpio_port_std.sv
module gpio_port_std
    import gpio_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      hw_stby,
    input  logic                      sw_stby,
    input  logic [gpio_pkg::ADDR_W-1:0] addr,
    input  logic                      wr_en,
    input  logic                      rd_en,
    input  logic [WIDTH-1:0]          wr_data,
    output logic [WIDTH-1:0]          rd_data,
    input  logic [WIDTH-1:0]          pin_in,
    output logic [WIDTH-1:0]          pin_out,
    output logic [WIDTH-1:0]          pin_oe
);
    pwr_mode_e        mode;
    reg_sel_e         sel;
    logic [WIDTH-1:0] latch_q, dir_q, pins_sync;

    assign mode = pick_mode(hw_stby, sw_stby);
    assign sel  = reg_sel_e'(addr);

    gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .hold(mode == MODE_SW_HOLD),
        .async_in(pin_in), .sync_out(pins_sync)
    );

    gpio_regs #(.WIDTH(WIDTH)) u_regs (
        .clk(clk), .rst(rst), .mode(mode), .wr_en(wr_en), .sel(sel),
        .wr_data(wr_data), .latch_q(latch_q), .dir_q(dir_q)
    );

    gpio_rdmux #(.WIDTH(WIDTH)) u_rd (
        .clk(clk), .rst(rst), .rd_en(rd_en), .sel(sel),
        .latch_q(latch_q), .dir_q(dir_q), .pins_sync(pins_sync),
        .rd_q(rd_data)
    );

    assign pin_out = latch_q;
    assign pin_oe  = dir_q;
endmodule

// File: rtl/gpio_port_std_chk.sv
module gpio_port_std_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             hw_stby,
    input logic             sw_stby,
    input logic [1:0]       addr,
    input logic             wr_en,
    input logic             rd_en,
    input logic [WIDTH-1:0] wr_data,
    input logic [WIDTH-1:0] rd_data,
    input logic [WIDTH-1:0] pin_out,
    input logic [WIDTH-1:0] pin_oe
);
    // R1
    p_reset_clears_r1: assert property (@(posedge clk)
        rst |=> (rd_data == '0 && pin_oe == '0 && pin_out == '0));

    // R2
    p_latch_write_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 2'd0 && !hw_stby && !sw_stby) |=> pin_out == $past(wr_data));

    // R3
    p_dir_write_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 2'd1 && !hw_stby && !sw_stby) |=> pin_oe == $past(wr_data));

    // R6
    p_status_nowrite_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 2'd2 && !hw_stby) |=> ($stable(pin_out) && $stable(pin_oe)));

    // R7
    p_rdata_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));

    // R8 and R10
    p_hw_clear_r8: assert property (@(posedge clk) disable iff (rst)
        hw_stby |=> (pin_out == '0 && pin_oe == '0));

    // R9
    p_sw_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (sw_stby && !hw_stby) |=> ($stable(pin_out) && $stable(pin_oe)));
endmodule

bind gpio_port_std gpio_port_std_chk #(.WIDTH(WIDTH)) u_chk (
    .clk(clk), .rst(rst), .hw_stby(hw_stby), .sw_stby(sw_stby),
    .addr(addr), .wr_en(wr_en), .rd_en(rd_en), .wr_data(wr_data),
    .rd_data(rd_data), .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/tb_gpio_port_std.sv
`timescale 1ns/1ps
module tb_gpio_port_std;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         hw_stby = 1'b0, sw_stby = 1'b0;
    logic [1:0]   addr = '0;
    logic         wr_en = 1'b0, rd_en = 1'b0;
    logic [W-1:0] wr_data = '0, rd_data, pin_in = '0, pin_out, pin_oe;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    gpio_port_std dut (
        .clk(clk), .rst(rst), .hw_stby(hw_stby), .sw_stby(sw_stby),
        .addr(addr), .wr_en(wr_en), .rd_en(rd_en), .wr_data(wr_data),
        .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [W-1:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        tick(1);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [W-1:0] d);
        addr = a; rd_en = 1'b1;
        tick(1);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic t_reset;
        check("R1 rd_data", rd_data, 8'h00);
        check("R1 pin_oe", pin_oe, 8'h00);
        check("R1 pin_out", pin_out, 8'h00);
    endtask

    task automatic t_regs;
        logic [W-1:0] d;
        bus_wr(2'd0, 8'hC3);
        check("R2 pin_out", pin_out, 8'hC3);
        bus_rd(2'd0, d); check("R2 readback", d, 8'hC3);
        bus_wr(2'd1, 8'h3C);
        check("R3 pin_oe", pin_oe, 8'h3C);
        bus_rd(2'd1, d); check("R3 readback", d, 8'h3C);
    endtask

    task automatic t_status_mix;
        logic [W-1:0] d;
        bus_wr(2'd0, 8'h0F);
        pin_in = 8'hF0;
        bus_wr(2'd1, 8'h00); tick(3);
        bus_rd(2'd2, d); check("R4 all inputs", d, 8'hF0);
        bus_wr(2'd1, 8'hFF);
        bus_rd(2'd2, d); check("R4 all outputs", d, 8'h0F);
        bus_wr(2'd1, 8'hA5);
        bus_rd(2'd2, d); check("R4 mixed", d, (8'h0F & 8'hA5) | (8'hF0 & 8'h5A));
    endtask

    task automatic t_sync;
        logic [W-1:0] d;
        bus_wr(2'd1, 8'h00);
        pin_in = 8'h00; tick(4);
        pin_in = 8'h99;
        tick(1);
        bus_rd(2'd2, d); check("R5 two-flop old", d, 8'h00);
        bus_rd(2'd2, d); check("R5 two-flop new", d, 8'h99);
    endtask

    task automatic t_status_write;
        logic [W-1:0] d;
        bus_wr(2'd0, 8'h12);
        bus_wr(2'd1, 8'h34);
        bus_wr(2'd2, 8'hFF);
        bus_rd(2'd0, d); check("R6 latch kept", d, 8'h12);
        bus_rd(2'd1, d); check("R6 dir kept", d, 8'h34);
    endtask

    task automatic t_rdreg;
        logic [W-1:0] d;
        bus_wr(2'd0, 8'h6E);
        bus_rd(2'd0, d); check("R7 read", d, 8'h6E);
        bus_wr(2'd0, 8'h11);
        tick(2);
        check("R7 hold without strobe", rd_data, 8'h6E);
        bus_rd(2'd3, d); check("R7 unused addr", d, 8'h00);
    endtask

    task automatic t_hw;
        logic [W-1:0] d;
        bus_wr(2'd0, 8'h77);
        bus_wr(2'd1, 8'hFF);
        pin_in = 8'h2B;
        hw_stby = 1'b1;
        bus_wr(2'd0, 8'h11);
        tick(2);
        check("R8 latch cleared", pin_out, 8'h00);
        check("R8 dir cleared", pin_oe, 8'h00);
        hw_stby = 1'b0;
        tick(1);
        bus_rd(2'd2, d); check("R8 status shows pins", d, 8'h2B);
    endtask

    task automatic t_sw;
        logic [W-1:0] d;
        bus_wr(2'd0, 8'h5A);
        bus_wr(2'd1, 8'h0F);
        pin_in = 8'h30; tick(3);
        bus_rd(2'd2, d); check("R9 pre-standby status", d, 8'h3A);
        sw_stby = 1'b1;
        pin_in = 8'hC0;
        bus_wr(2'd0, 8'hFF);
        bus_wr(2'd1, 8'hF0);
        tick(4);
        bus_rd(2'd2, d); check("R9 status frozen", d, 8'h3A);
        bus_rd(2'd0, d); check("R9 latch kept", d, 8'h5A);
        bus_rd(2'd1, d); check("R9 dir kept", d, 8'h0F);
        sw_stby = 1'b0;
        tick(3);
        bus_rd(2'd2, d); check("R9 resumes", d, 8'hCA);
    endtask

    task automatic t_prio;
        bus_wr(2'd0, 8'hE7);
        bus_wr(2'd1, 8'h81);
        sw_stby = 1'b1; hw_stby = 1'b1;
        tick(1);
        check("R10 latch cleared", pin_out, 8'h00);
        check("R10 dir cleared", pin_oe, 8'h00);
        sw_stby = 1'b0; hw_stby = 1'b0;
        tick(1);
    endtask

    initial begin
        tick(3);
        t_reset();
        rst = 1'b0;
        tick(1);
        t_regs();
        t_status_mix();
        t_sync();
        t_status_write();
        t_rdreg();
        t_hw();
        t_sw();
        t_prio();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule